// File: doc/BRIEF.md
# Parallel Dot-Product Reduction Engine

This engine produces one element of a matrix product. It takes a row of the left matrix and a column of the right matrix, each holding `LEN` signed integer elements, and returns their inner product. A start pulse latches both vectors and a per-lane enable mask. The engine then forms every element-wise product in one cycle. After that it folds the partial sums in place, one level per clock, until the total sits in the lowest slot.

At fold level `s` (counting from 1), the slot at zero-based index `k` takes in slot `k + 2^(s-1)` if `k` is a multiple of `2^s`. All other slots keep their values. The array therefore halves its live slots on every level, and `log2(LEN)` levels are enough. Lanes whose enable bit is cleared act as zero padding. This lets a shorter vector run on a wider engine without changing the result.

A system replicates the engine once per output element and drives `start` when the operands are ready. It reads `sum_out` on the cycle `done` is high. The result stays on `sum_out` while the engine is idle.

Top module: `dot_reduce_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy` and `done` are 0 and `sum_out` is 0.
- R2: `start` sampled high while `busy` is 0 latches `a_vec`, `b_vec` and `lane_en`. Later changes to those inputs do not affect that operation's result.
- R3: The result equals the exact sum over lanes of signed(a lane) × signed(b lane). Lane `k` occupies bits `[k*ELEM_W +: ELEM_W]`, and the result is `2*ELEM_W + log2(LEN)` bits wide and signed, so it never overflows.
- R4: `done` is high exactly `log2(LEN) + 1` rising edges after the edge that accepted `start`: one multiply edge plus one edge per fold level.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `busy` is 1 from the cycle after an accepted start through the `done` cycle. `start` has no effect while `busy` is 1, including the `done` cycle.
- R7: A lane whose `lane_en` bit is 0 adds nothing to the result, whatever its operand values.
- R8: All-extreme vectors give exact results: every lane −2^31 × −2^31 yields LEN·2^62, and −2^31 × (2^31−1) yields its exact negative total.
- R9: A `start` held high is accepted again on the first cycle after `done`, so operations run back to back with one idle cycle between them.
- R10: While `busy` is 0, `sum_out` keeps the last result and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation, honoured only when idle |
| lane_en | input | LEN | Per-lane enable; a cleared bit pads that lane with zero |
| a_vec | input | LEN*ELEM_W | Left operand vector, lane k at bits [k*ELEM_W +: ELEM_W], signed |
| b_vec | input | LEN*ELEM_W | Right operand vector, same packing, signed |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle strobe marking a valid result |
| sum_out | output | 2*ELEM_W+log2(LEN) | Signed inner product |

## Verification
The bench builds the engine with 32-bit elements and eight lanes. That gives three fold levels, so the done strobe comes on the fourth edge after acceptance. The eight lanes are enough to put every fold pattern in play: pairs, quads and the final merge. They also make the all-extreme totals need the guard bits: 2^65 does not fit in 64 bits. Random operands with random masks exercise the padding. Deliberate start pulses during the busy and done cycles, and operand changes mid-flight, exercise the latch and ignore rules.

// File: rtl/dotp_pkg.sv
`timescale 1ns/1ps
package dotp_pkg;

    // Control phases of one reduction
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_FOLD = 2'd2,
        PH_DONE = 2'd3
    } dotp_phase_e;

    // Number of fold levels for a lane count
    function automatic int fold_levels(input int lanes);
        return (lanes <= 1) ? 1 : $clog2(lanes);
    endfunction

    // Slot k (zero-based) absorbs a partner at level lvl (one-based)
    function automatic bit slot_active(input int k, input int lvl);
        return (k % (1 << lvl)) == 0;
    endfunction

    // Partner slot index, clamped to the array
    function automatic int partner_slot(input int k, input int lvl, input int lanes);
        int p;
        p = k + (1 << (lvl - 1));
        return (p < lanes) ? p : lanes - 1;
    endfunction

endpackage

// File: rtl/dotp_ctrl.sv
`timescale 1ns/1ps
module dotp_ctrl
    import dotp_pkg::*;
#(
    parameter int LVLS  = 3,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load_ops,
    output logic             write_prod,
    output logic             fold_en,
    output logic [LVL_W-1:0] level,
    output logic             busy,
    output logic             done
);

    dotp_phase_e phase_q;
    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            level_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) phase_q <= PH_MUL;
                end
                PH_MUL: begin
                    phase_q <= PH_FOLD;
                    level_q <= LVL_W'(1);
                end
                PH_FOLD: begin
                    if (level_q == LVL_W'(LVLS)) begin
                        phase_q <= PH_DONE;
                        level_q <= '0;
                    end else begin
                        level_q <= level_q + LVL_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign load_ops   = (phase_q == PH_IDLE) && start;
    assign write_prod = (phase_q == PH_MUL);
    assign fold_en    = (phase_q == PH_FOLD);
    assign level      = level_q;
    assign busy       = (phase_q != PH_IDLE);
    assign done       = (phase_q == PH_DONE);

endmodule

// File: rtl/dotp_mul_array.sv
`timescale 1ns/1ps
module dotp_mul_array #(
    parameter int ELEM_W = 32,
    parameter int LEN    = 8,
    parameter int SUM_W  = 67
) (
    input  logic [LEN*ELEM_W-1:0]     a_ops,
    input  logic [LEN*ELEM_W-1:0]     b_ops,
    input  logic [LEN-1:0]            lane_on,
    output logic [LEN-1:0][SUM_W-1:0] prod
);

    localparam int PROD_W = 2 * ELEM_W;

    for (genvar k = 0; k < LEN; k++) begin : g_lane
        logic signed [ELEM_W-1:0] a_el;
        logic signed [ELEM_W-1:0] b_el;
        logic signed [PROD_W-1:0] p_full;
        assign a_el   = a_ops[k*ELEM_W +: ELEM_W];
        assign b_el   = b_ops[k*ELEM_W +: ELEM_W];
        assign p_full = PROD_W'(a_el) * PROD_W'(b_el);
        assign prod[k] = lane_on[k] ? SUM_W'(p_full) : '0;
    end

endmodule

// File: rtl/dotp_fold_level.sv
`timescale 1ns/1ps
module dotp_fold_level
    import dotp_pkg::*;
#(
    parameter int LEN   = 8,
    parameter int SUM_W = 67,
    parameter int LVLS  = 3,
    parameter int LVL_W = 2
) (
    input  logic [LEN-1:0][SUM_W-1:0] cur,
    input  logic [LVL_W-1:0]          level,
    output logic [LEN-1:0][SUM_W-1:0] nxt
);

    always_comb begin
        for (int k = 0; k < LEN; k++) begin
            nxt[k] = cur[k];
            for (int l = 1; l <= LVLS; l++) begin
                if (level == LVL_W'(l) && slot_active(k, l)) begin
                    nxt[k] = cur[k] + cur[partner_slot(k, l, LEN)];
                end
            end
        end
    end

endmodule

// File: rtl/dot_reduce_engine.sv
`timescale 1ns/1ps
module dot_reduce_engine
    import dotp_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int LEN    = 8,
    localparam int LVLS  = fold_levels(LEN),
    localparam int SUM_W = 2 * ELEM_W + LVLS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [LEN-1:0]        lane_en,
    input  logic [LEN*ELEM_W-1:0] a_vec,
    input  logic [LEN*ELEM_W-1:0] b_vec,
    output logic                  busy,
    output logic                  done,
    output logic [SUM_W-1:0]      sum_out
);

    localparam int LVL_W = $clog2(LVLS + 1);

    logic                      load_ops;
    logic                      write_prod;
    logic                      fold_en;
    logic [LVL_W-1:0]          level;
    logic [LEN*ELEM_W-1:0]     a_q;
    logic [LEN*ELEM_W-1:0]     b_q;
    logic [LEN-1:0]            en_q;
    logic [LEN-1:0][SUM_W-1:0] prod;
    logic [LEN-1:0][SUM_W-1:0] slots_q;
    logic [LEN-1:0][SUM_W-1:0] slots_nxt;

    dotp_ctrl #(
        .LVLS (LVLS),
        .LVL_W(LVL_W)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_ops  (load_ops),
        .write_prod(write_prod),
        .fold_en   (fold_en),
        .level     (level),
        .busy      (busy),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            en_q <= '0;
        end else if (load_ops) begin
            a_q  <= a_vec;
            b_q  <= b_vec;
            en_q <= lane_en;
        end
    end

    dotp_mul_array #(
        .ELEM_W(ELEM_W),
        .LEN   (LEN),
        .SUM_W (SUM_W)
    ) i_mul (
        .a_ops  (a_q),
        .b_ops  (b_q),
        .lane_on(en_q),
        .prod   (prod)
    );

    dotp_fold_level #(
        .LEN  (LEN),
        .SUM_W(SUM_W),
        .LVLS (LVLS),
        .LVL_W(LVL_W)
    ) i_fold (
        .cur  (slots_q),
        .level(level),
        .nxt  (slots_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (write_prod) begin
            slots_q <= prod;
        end else if (fold_en) begin
            slots_q <= slots_nxt;
        end
    end

    assign sum_out = slots_q[0];

endmodule

// File: rtl/dotp_checker.sv
`timescale 1ns/1ps
module dotp_checker #(
    parameter int LEN   = 8,
    parameter int SUM_W = 67
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [SUM_W-1:0] sum_out
);

    localparam int LVLS = dotp_pkg::fold_levels(LEN);

    logic        run_q;
    int unsigned edges_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            edges_q <= 0;
        end else if (!busy && start) begin
            run_q   <= 1'b1;
            edges_q <= 0;
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            edges_q <= edges_q + 1;
        end
    end

    // R4: done lands exactly one multiply edge plus LVLS fold edges after acceptance
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_q && edges_q == LVLS + 1));

    // R5: single-cycle strobe
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: an accepted start raises busy without an immediate done
    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done));

    // R6: busy cannot drop before the done cycle
    p_busy_held_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R10: result held while idle
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(sum_out));

endmodule

bind dot_reduce_engine dotp_checker #(
    .LEN  (LEN),
    .SUM_W(SUM_W)
) i_dotp_checker (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .sum_out(sum_out)
);

// File: tb/test_dot_reduce_engine.sv
`timescale 1ns/1ps
module test_dot_reduce_engine;

    localparam int ELEM_W = 32;
    localparam int LEN    = 8;
    localparam int LVLS   = $clog2(LEN);
    localparam int SUM_W  = 2 * ELEM_W + LVLS;

    typedef logic signed [SUM_W-1:0] sw_t;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic [LEN-1:0]        lane_en = '1;
    logic [LEN*ELEM_W-1:0] a_vec = '0;
    logic [LEN*ELEM_W-1:0] b_vec = '0;
    logic                  busy;
    logic                  done;
    logic [SUM_W-1:0]      sum_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    int  m_cnt  = 0;
    bit  m_done = 1'b0;
    bit  m_have = 1'b0;
    sw_t m_pend = '0;
    sw_t m_last = '0;

    always #2.5 clk = ~clk;

    dot_reduce_engine #(
        .ELEM_W(ELEM_W),
        .LEN   (LEN)
    ) i_dot_reduce_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .lane_en(lane_en),
        .a_vec  (a_vec),
        .b_vec  (b_vec),
        .busy   (busy),
        .done   (done),
        .sum_out(sum_out)
    );

    task automatic chk(input bit ok, input string req, input sw_t act, input sw_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic sw_t ref_dot(input logic [LEN*ELEM_W-1:0] av,
                                    input logic [LEN*ELEM_W-1:0] bv,
                                    input logic [LEN-1:0] en);
        sw_t acc;
        acc = '0;
        for (int k = 0; k < LEN; k++) begin
            logic signed [ELEM_W-1:0] x;
            logic signed [ELEM_W-1:0] y;
            x = av[k*ELEM_W +: ELEM_W];
            y = bv[k*ELEM_W +: ELEM_W];
            if (en[k]) acc = acc + sw_t'(x) * sw_t'(y);
        end
        return acc;
    endfunction

    // One clock: advance the model with the inputs seen at the edge, then compare
    task automatic tick();
        bit exp_busy;
        @(posedge clk);
        if (m_done) begin
            m_done = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1'b1;
                m_last = m_pend;
                m_have = 1'b1;
            end
        end else if (start) begin
            m_cnt  = LVLS + 1;                              // R2: operands latched here
            m_pend = ref_dot(a_vec, b_vec, lane_en);
        end
        #1;
        exp_busy = (m_cnt > 0) || m_done;
        chk(busy == exp_busy, "R6 busy", sw_t'(busy), sw_t'(exp_busy));
        chk(done == m_done, "R4/R5 done timing", sw_t'(done), sw_t'(m_done));
        if (m_done)
            chk(sum_out == m_last, "R3 result", sw_t'(sum_out), m_last);
        if (!exp_busy && m_have)
            chk(sum_out == m_last, "R10 idle hold", sw_t'(sum_out), m_last);
    endtask

    task automatic set_ops(input logic signed [ELEM_W-1:0] av,
                           input logic signed [ELEM_W-1:0] bv);
        for (int k = 0; k < LEN; k++) begin
            a_vec[k*ELEM_W +: ELEM_W] = av;
            b_vec[k*ELEM_W +: ELEM_W] = bv;
        end
    endtask

    task automatic set_random();
        for (int k = 0; k < LEN; k++) begin
            a_vec[k*ELEM_W +: ELEM_W] = $urandom;
            b_vec[k*ELEM_W +: ELEM_W] = $urandom;
        end
    endtask

    // Launch one operation and run it to idle; optionally disturb inputs mid-flight
    task automatic run_op(input bit disturb);
        start = 1'b1;
        tick();
        start = 1'b0;
        while ((m_cnt > 0) || m_done) begin
            if (disturb) begin
                set_random();                  // R2: must not change the result
                lane_en = LEN'($urandom);
                start   = 1'b1;                // R6: must be ignored
            end
            tick();
        end
        start = 1'b0;
        tick();
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R1 busy in reset", sw_t'(busy), '0);
        chk(done == 1'b0, "R1 done in reset", sw_t'(done), '0);
        chk(sum_out == '0, "R1 sum in reset", sw_t'(sum_out), '0);
        rst = 1'b0;
        tick();
        chk(sum_out == '0, "R1 sum after reset", sw_t'(sum_out), '0);

        // R3: all-zero vectors
        lane_en = '1;
        set_ops('0, '0);
        run_op(1'b0);

        // R8: most negative squared in every lane -> LEN * 2^62
        set_ops(32'sh8000_0000, 32'sh8000_0000);
        run_op(1'b0);
        chk(sum_out == (sw_t'(LEN) <<< 62), "R8 max positive", sw_t'(sum_out), sw_t'(LEN) <<< 62);

        // R8: most negative times most positive
        set_ops(32'sh8000_0000, 32'sh7fff_ffff);
        run_op(1'b0);

        // R7: partial lane masks with nonzero operands
        set_ops(32'sd1000, 32'sd7);
        lane_en = 8'b0000_0101;
        run_op(1'b0);
        chk(sum_out == sw_t'(14000), "R7 two lanes", sw_t'(sum_out), sw_t'(14000));
        lane_en = '0;
        set_random();
        run_op(1'b0);
        chk(sum_out == '0, "R7 all lanes off", sw_t'(sum_out), '0);

        // R2/R6: disturbed inputs and stray starts during busy and done
        lane_en = '1;
        for (int n = 0; n < 6; n++) begin
            set_random();
            lane_en = (n % 2 == 0) ? '1 : LEN'($urandom);
            run_op(1'b1);
        end

        // R9: start held high -> back-to-back acceptance after each done
        lane_en = '1;
        set_random();
        start = 1'b1;
        for (int c = 0; c < 4 * (LVLS + 3); c++) tick();
        start = 1'b0;
        while ((m_cnt > 0) || m_done) tick();
        tick();

        // R3: random vectors and masks
        for (int n = 0; n < 40; n++) begin
            set_random();
            lane_en = (n < 20) ? '1 : LEN'($urandom);
            run_op(1'b0);
        end

        // R10: long idle hold
        repeat (10) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule